// File: doc/BRIEF.md
# Start-Validated Serial Character Receiver

This block turns an asynchronous start-stop serial line into parallel characters. It runs on a receive clock that is 1, 16 or 64 times the bit rate. The line first passes through a two-flop synchronizer. A high-to-low transition marks a candidate start bit. The receiver samples the line again at the middle of that bit and drops the candidate if the line has already gone back high. Each confirmed character is assembled least-significant bit first. An optional parity bit and the stop bit are then checked, and the character is moved into a holding buffer that a host reads.

The host watches a ready flag and takes the character. A one-cycle read pulse clears the flag. Each buffered character carries its own parity and framing error flags. A sticky overrun flag records that a new character replaced one that had not been read. A separate break output reports a line held low for longer than a whole character frame. Character length, parity mode and clock factor are static configuration inputs.

Top module: `async_char_rx`

## Requirements
- R1: After reset, rxReady, parityErr, frameErr, overrun and breakDet are all 0.
- R2: A low pulse on serialIn that ends before the middle of the start bit produces no character, and the next proper character is received correctly.
- R3: cfgLen selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits are received least-significant first into rxData[0] upward, and the unused upper rxData bits read 0.
- R4: cfgFactor selects the receive clock factor: 0 gives 1x, 1 gives 16x, and 2 or 3 give 64x. At every factor, characters sent at the matching bit length of 1, 16 or 64 clocks are received correctly.
- R5: When cfgParityEn is 1, one parity bit follows the data. Even parity is selected by cfgParityOdd=0 and odd parity by 1. parityErr is set with the character when the count of ones in the data and parity bits does not match the selected mode, and it is 0 when parity is disabled.
- R6: frameErr is set with the character when the stop bit is sampled low, and it is 0 otherwise.
- R7: When a character completes, rxReady goes high with rxData holding that character. A readPulse while no character completes clears rxReady on the next clock.
- R8: If a character completes while rxReady is high and no readPulse is present, rxData is overwritten and overrun goes high. overrun then stays high until reset.
- R9: breakDet rises when the synchronized line has stayed low for (2 + data bits + parity bit) bit times. It falls after the line has been high for one bit time.
- R10: A new start bit is recognised only on a high-to-low transition. A line held low after a character produces no further characters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock (1x, 16x or 64x the bit rate) |
| rstN | input | 1 | Active-low asynchronous reset |
| serialIn | input | 1 | Asynchronous serial line, idle high |
| cfgLen | input | 2 | Data length code, 0..3 means 5..8 bits |
| cfgParityEn | input | 1 | Enables the parity bit |
| cfgParityOdd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfgFactor | input | 2 | Clock factor: 0 gives 1x, 1 gives 16x, 2 or 3 give 64x |
| readPulse | input | 1 | Host read strobe, clears rxReady |
| rxData | output | 8 | Buffered received character |
| rxReady | output | 1 | A character is waiting in the buffer |
| parityErr | output | 1 | Parity error of the buffered character |
| frameErr | output | 1 | Framing error of the buffered character |
| overrun | output | 1 | Sticky flag: an unread character was overwritten |
| breakDet | output | 1 | Line held low longer than a full frame |

## Verification
The bench builds the receiver with its default parameters: up to 8 data bits, a mid factor of 16 and a top factor of 64. The clock factor is an input rather than a parameter, so a single build covers 1x, 16x and 64x operation. The same build also reaches every data length and both parity senses. That is enough for the 1x path, which skips the half-bit confirmation, and for the 704-clock break window of the longest frame at 64x. The short break limit at 16x keeps the break and break-recovery cases quick to reach.

// File: rtl/rx_pkg.sv
package rx_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rxState_e;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic clearShift;
    logic takeData;
    logic takeParity;
    logic commit;
  } rxStrobe_t;

endpackage

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import rx_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int BIT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineS,
  input  logic             fallEdge,
  input  logic [CNT_W-1:0] divisor,
  input  logic [BIT_W-1:0] lenBits,
  input  logic             parityEn,
  output rxStrobe_t        strobes,
  output logic [BIT_W-1:0] bitIdx
);

  rxState_e         state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] halfDiv;
  logic             atBit;

  assign halfDiv = divisor >> 1;
  assign atBit   = (cnt == divisor);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_HUNT;
      cnt    <= '0;
      bitIdx <= '0;
    end else begin
      case (state)
        ST_HUNT: begin
          cnt    <= CNT_W'(1);
          bitIdx <= '0;
          if (fallEdge) state <= (halfDiv == '0) ? ST_DATA : ST_START;
        end
        ST_START: begin
          if (cnt == halfDiv) begin
            cnt   <= CNT_W'(1);
            state <= lineS ? ST_HUNT : ST_DATA;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_DATA: begin
          if (atBit) begin
            cnt <= CNT_W'(1);
            if (bitIdx == lenBits - BIT_W'(1)) begin
              bitIdx <= '0;
              state  <= parityEn ? ST_PARITY : ST_STOP;
            end else begin
              bitIdx <= bitIdx + BIT_W'(1);
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_PARITY: begin
          if (atBit) begin
            cnt   <= CNT_W'(1);
            state <= ST_STOP;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_STOP: begin
          if (atBit) state <= ST_HUNT;
          else       cnt   <= cnt + CNT_W'(1);
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  always_comb begin
    strobes = '0;
    // Shift register is cleared whenever a start bit is accepted.
    strobes.clearShift = ((state == ST_HUNT) && fallEdge && (halfDiv == '0)) ||
                         ((state == ST_START) && (cnt == halfDiv) && !lineS);
    strobes.takeData   = (state == ST_DATA)   && atBit;
    strobes.takeParity = (state == ST_PARITY) && atBit;
    strobes.commit     = (state == ST_STOP)   && atBit;
  end

endmodule

// File: rtl/rx_dpath.sv
module rx_dpath
  import rx_pkg::*;
#(
  parameter int MAX_BITS = 8,
  parameter int CNT_W    = 7,
  parameter int BIT_W    = 4,
  parameter int BRK_W    = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                serialIn,
  input  rxStrobe_t           strobes,
  input  logic [BIT_W-1:0]    bitIdx,
  input  logic [CNT_W-1:0]    divisor,
  input  logic [BRK_W-1:0]    breakLimit,
  input  logic                parityEn,
  input  logic                parityOdd,
  input  logic                readPulse,
  output logic                lineS,
  output logic                fallEdge,
  output logic [MAX_BITS-1:0] rxData,
  output logic                rxReady,
  output logic                parityErr,
  output logic                frameErr,
  output logic                overrun,
  output logic                breakDet
);

  logic                syncA, lineD;
  logic [MAX_BITS-1:0] shReg;
  logic                parAcc;
  logic [BRK_W-1:0]    lowCnt;
  logic [CNT_W-1:0]    highCnt;

  // Two-flop synchronizer plus one delay for edge detection.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b1;
      lineS <= 1'b1;
      lineD <= 1'b1;
    end else begin
      syncA <= serialIn;
      lineS <= syncA;
      lineD <= lineS;
    end
  end

  assign fallEdge = lineD & ~lineS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      parAcc <= 1'b0;
    end else if (strobes.clearShift) begin
      shReg  <= '0;
      parAcc <= 1'b0;
    end else if (strobes.takeData) begin
      for (int i = 0; i < MAX_BITS; i++)
        if (bitIdx == BIT_W'(i)) shReg[i] <= lineS;
      parAcc <= parAcc ^ lineS;
    end else if (strobes.takeParity) begin
      parAcc <= parAcc ^ lineS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData    <= '0;
      rxReady   <= 1'b0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
      overrun   <= 1'b0;
    end else if (strobes.commit) begin
      rxData    <= shReg;
      rxReady   <= 1'b1;
      parityErr <= parityEn & (parAcc ^ parityOdd);
      frameErr  <= ~lineS;
      if (rxReady && !readPulse) overrun <= 1'b1;
    end else if (readPulse) begin
      rxReady <= 1'b0;
    end
  end

  // Break: run length of low samples against a whole frame.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt   <= '0;
      highCnt  <= '0;
      breakDet <= 1'b0;
    end else if (!lineS) begin
      highCnt <= '0;
      if (lowCnt != '1) lowCnt <= lowCnt + BRK_W'(1);
      if (lowCnt >= breakLimit - BRK_W'(1)) breakDet <= 1'b1;
    end else begin
      lowCnt <= '0;
      if (highCnt != '1) highCnt <= highCnt + CNT_W'(1);
      if (breakDet && (highCnt >= divisor - CNT_W'(1))) breakDet <= 1'b0;
    end
  end

endmodule

// File: rtl/async_char_rx.sv
module async_char_rx
  import rx_pkg::*;
#(
  parameter int MAX_BITS   = 8,
  parameter int FACTOR_MID = 16,
  parameter int FACTOR_MAX = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                serialIn,
  input  logic [1:0]          cfgLen,
  input  logic                cfgParityEn,
  input  logic                cfgParityOdd,
  input  logic [1:0]          cfgFactor,
  input  logic                readPulse,
  output logic [MAX_BITS-1:0] rxData,
  output logic                rxReady,
  output logic                parityErr,
  output logic                frameErr,
  output logic                overrun,
  output logic                breakDet
);

  localparam int CNT_W = $clog2(FACTOR_MAX + 1);
  localparam int BIT_W = $clog2(MAX_BITS + 4);
  localparam int BRK_W = $clog2(FACTOR_MAX * (MAX_BITS + 3) + 1);

  logic [CNT_W-1:0] divisor;
  logic [BIT_W-1:0] lenBits;
  logic [BIT_W-1:0] frameBits;
  logic [BRK_W-1:0] breakLimit;
  logic [BIT_W-1:0] bitIdx;
  logic             lineS, fallEdge;
  rxStrobe_t        strobes;

  always_comb begin
    case (cfgFactor)
      2'd0:    divisor = CNT_W'(1);
      2'd1:    divisor = CNT_W'(FACTOR_MID);
      default: divisor = CNT_W'(FACTOR_MAX);
    endcase
  end

  assign lenBits    = BIT_W'(cfgLen) + BIT_W'(MAX_BITS - 3);
  assign frameBits  = lenBits + BIT_W'(cfgParityEn) + BIT_W'(2);
  assign breakLimit = BRK_W'(divisor) * BRK_W'(frameBits);

  rx_ctrl #(.CNT_W(CNT_W), .BIT_W(BIT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .lineS(lineS), .fallEdge(fallEdge),
    .divisor(divisor), .lenBits(lenBits), .parityEn(cfgParityEn),
    .strobes(strobes), .bitIdx(bitIdx)
  );

  rx_dpath #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W), .BIT_W(BIT_W), .BRK_W(BRK_W)) i_dpath (
    .clk(clk), .rstN(rstN), .serialIn(serialIn), .strobes(strobes),
    .bitIdx(bitIdx), .divisor(divisor), .breakLimit(breakLimit),
    .parityEn(cfgParityEn), .parityOdd(cfgParityOdd), .readPulse(readPulse),
    .lineS(lineS), .fallEdge(fallEdge), .rxData(rxData), .rxReady(rxReady),
    .parityErr(parityErr), .frameErr(frameErr), .overrun(overrun),
    .breakDet(breakDet)
  );

endmodule

// File: rtl/rx_checker.sv
module rx_checker (
  input logic clk,
  input logic rstN,
  input logic readPulse,
  input logic rxReady,
  input logic overrun,
  input logic breakDet,
  input logic lineS,
  input logic commit
);

  assert_ready_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> rxReady);

  assert_ready_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (readPulse && !commit) |=> !rxReady);

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> ($past(commit) && $past(rxReady)));

  assert_break_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(breakDet) |-> !$past(lineS));

  assert_break_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(breakDet) |-> $past(lineS));

endmodule

bind async_char_rx rx_checker i_rx_checker (
  .clk(clk), .rstN(rstN), .readPulse(readPulse), .rxReady(rxReady),
  .overrun(overrun), .breakDet(breakDet), .lineS(lineS),
  .commit(strobes.commit)
);

// File: tb/test_async_char_rx.sv
`timescale 1ns/1ps
module test_async_char_rx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serialIn = 1'b1;
  logic [1:0] cfgLen = 2'd3;
  logic       cfgParityEn = 1'b0;
  logic       cfgParityOdd = 1'b0;
  logic [1:0] cfgFactor = 2'd1;
  logic       readPulse = 1'b0;
  logic [7:0] rxData;
  logic       rxReady, parityErr, frameErr, overrun, breakDet;

  int checks = 0;
  int errors = 0;
  int dv = 16;
  logic holdRead = 1'b0;
  logic manualRead = 1'b0;
  logic prevR = 1'b0;

  typedef struct { logic [7:0] d; logic pe; logic fe; string req; } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  async_char_rx i_async_char_rx (
    .clk(clk), .rstN(rstN), .serialIn(serialIn), .cfgLen(cfgLen),
    .cfgParityEn(cfgParityEn), .cfgParityOdd(cfgParityOdd),
    .cfgFactor(cfgFactor), .readPulse(readPulse), .rxData(rxData),
    .rxReady(rxReady), .parityErr(parityErr), .frameErr(frameErr),
    .overrun(overrun), .breakDet(breakDet)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v);
    serialIn = v;
    repeat (dv) @(negedge clk);
  endtask

  task automatic setFactor(input logic [1:0] f);
    cfgFactor = f;
    dv = (f == 2'd0) ? 1 : (f == 2'd1) ? 16 : 64;
  endtask

  // Driver: pushes the expected result, then drives one frame.
  task automatic sendChar(input logic [7:0] d, input int len, input logic badPar,
                          input logic badStop, input logic push, input string req);
    logic [7:0] m;
    logic pb;
    exp_t e;
    m = d & 8'((1 << len) - 1);
    pb = (^m) ^ cfgParityOdd ^ badPar;
    e.d = m; e.pe = cfgParityEn & badPar; e.fe = badStop; e.req = req;
    if (push) q.push_back(e);
    drive(1'b0);
    for (int i = 0; i < len; i++) drive(m[i]);
    if (cfgParityEn) drive(pb);
    drive(~badStop);
    serialIn = 1'b1;
    repeat (2 * dv + 4) @(negedge clk);
  endtask

  // Monitor: pops and compares on each new character.
  initial begin
    forever begin
      @(negedge clk);
      readPulse = manualRead;
      if (rstN && rxReady && !prevR) begin
        if (q.size() == 0) begin
          check("R10 unexpected character", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check({e.req, " data"}, rxData, e.d);
          check({e.req, " R5 parityErr"}, parityErr, e.pe);
          check({e.req, " R6 frameErr"}, frameErr, e.fe);
        end
        if (!holdRead) readPulse = 1'b1;
      end
      prevR = rxReady;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rxReady", rxReady, 0);
    check("R1 flags", {parityErr, frameErr, overrun, breakDet}, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R3 / R4 at 16x, 8 bits
    sendChar(8'hA5, 8, 0, 0, 1, "R3 8bit 16x");
    check("R7 ready cleared by read", rxReady, 0);
    sendChar(8'h3C, 8, 0, 0, 1, "R4 16x");

    // R3: other lengths, upper bits zero
    cfgLen = 2'd0; sendChar(8'hFF, 5, 0, 0, 1, "R3 5bit");
    cfgLen = 2'd1; sendChar(8'hEA, 6, 0, 0, 1, "R3 6bit");
    cfgLen = 2'd2; sendChar(8'hD3, 7, 0, 0, 1, "R3 7bit");

    // R5: parity
    cfgParityEn = 1'b1; cfgParityOdd = 1'b0;
    sendChar(8'h55, 7, 0, 0, 1, "R5 even ok");
    sendChar(8'h55, 7, 1, 0, 1, "R5 even bad");
    cfgParityOdd = 1'b1; cfgLen = 2'd3;
    sendChar(8'h81, 8, 0, 0, 1, "R5 odd ok");
    sendChar(8'h81, 8, 1, 0, 1, "R5 odd bad");
    cfgParityEn = 1'b0;

    // R6: framing
    sendChar(8'h96, 8, 0, 1, 1, "R6 bad stop");
    sendChar(8'h69, 8, 0, 0, 1, "R6 good after bad");

    // R2: false start shorter than half a bit
    serialIn = 1'b0;
    repeat (4) @(negedge clk);
    serialIn = 1'b1;
    repeat (40) @(negedge clk);
    check("R2 no char from glitch", rxReady, 0);
    check("R2 queue empty", q.size(), 0);
    sendChar(8'hC3, 8, 0, 0, 1, "R2 char after glitch");

    // R4: 1x and 64x
    setFactor(2'd0);
    sendChar(8'h5A, 8, 0, 0, 1, "R4 1x");
    sendChar(8'hB1, 8, 0, 0, 1, "R4 1x back");
    setFactor(2'd2);
    sendChar(8'h7E, 8, 0, 0, 1, "R4 64x");
    setFactor(2'd1);
    check("R9 no break on traffic", breakDet, 0);

    // R9 / R10: break at 16x, 8 bits, no parity: limit 160 clocks
    begin
      exp_t e;
      e.d = 8'h00; e.pe = 1'b0; e.fe = 1'b1; e.req = "R10 break frame";
      q.push_back(e);
    end
    serialIn = 1'b0;
    repeat (120) @(negedge clk);
    check("R9 no break before frame", breakDet, 0);
    repeat (80) @(negedge clk);
    check("R9 break set", breakDet, 1);
    check("R10 single char in break", q.size(), 0);
    serialIn = 1'b1;
    repeat (6) @(negedge clk);
    check("R9 break held under one bit", breakDet, 1);
    repeat (24) @(negedge clk);
    check("R9 break cleared", breakDet, 0);
    repeat (20) @(negedge clk);

    // R8: overrun
    holdRead = 1'b1;
    sendChar(8'h11, 8, 0, 0, 1, "R8 first");
    check("R8 no overrun yet", overrun, 0);
    sendChar(8'h22, 8, 0, 0, 0, "R8 second");
    check("R8 overrun set", overrun, 1);
    check("R8 data overwritten", rxData, 8'h22);
    check("R8 still ready", rxReady, 1);
    @(posedge clk); manualRead = 1'b1;
    @(posedge clk); manualRead = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 manual read clears", rxReady, 0);
    check("R8 overrun sticky", overrun, 1);
    check("R3 scoreboard drained", q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule